// File: doc/BRIEF.md
# Out-of-Order Request Tracking Table

This block keeps a fixed number of slots for I/O requests that are in flight and may finish in any order. A requester asks for a slot and receives an index in the same cycle. The slot search resumes just past the slot granted last and wraps around, so indices are spread across the table instead of always reusing the lowest one. Later the slot index comes back with completion data: a reply word, a context flag and a context type. That data is stored and the slot is marked done. A separate port stamps a 64-bit time value into a slot. The slot is released when its consumer has taken the reply, and releases can happen in any order.

A combinational read port shows the full state of any slot. A synchronous clear empties the table and rewinds the search pointer. A completion, time stamp or release aimed at a slot that is not in use changes nothing. Instead it raises a protocol-error pulse for one cycle.

Top module: `tt_req_table`

## Requirements
- R1: After reset or clear, every slot reads back with used, done, context flag, context type, reply and time all zero, `proto_err` is low, and the first grant goes to index 0.
- R2: While `alloc_req` is high and a slot is free, `alloc_gnt` is high in the same cycle. `alloc_idx` names the first free slot, searching upward from the next pointer and wrapping from DEPTH-1 to 0. From the following cycle that slot reads as used.
- R3: After a grant the next pointer becomes the granted index plus one, and wraps to 0 past DEPTH-1.
- R4: A grant clears the slot's reply, context flag, context type, time and done bits.
- R5: When no slot is free, `alloc_full` is high and `alloc_gnt` stays low, and the table is left unchanged.
- R6: A completion to a used slot stores the reply, context flag and context type and sets done. All of these are visible on the read port one cycle later.
- R7: A release clears only the used bit. Done, reply, context and time stay readable.
- R8: Slots can be released in any order. A released slot is granted again only when the search reaches it from the next pointer.
- R9: An allocation in the same cycle as a release sees the table as it was before that release.
- R10: A completion, time stamp or release to a slot that is not used leaves the slot unchanged. It drives `proto_err` high for exactly the next cycle.
- R11: A time stamp to a used slot stores the 64-bit value, and it reads back one cycle later.
- R12: `clr` overrides every operation in the same cycle: no grant is issued, and the table and pointer are zeroed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of table and pointer |
| alloc_req | input | 1 | Request a slot |
| alloc_gnt | output | 1 | Slot granted this cycle |
| alloc_idx | output | IDX_W | Index of the slot granted (or next candidate) |
| alloc_full | output | 1 | No slot free |
| cmp_vld | input | 1 | Completion strobe |
| cmp_idx | input | IDX_W | Slot being completed |
| cmp_reply | input | REPLY_W | Reply word |
| cmp_ctx | input | 1 | Context flag |
| cmp_ctype | input | CTYPE_W | Context type |
| tset_vld | input | 1 | Time stamp strobe |
| tset_idx | input | IDX_W | Slot being stamped |
| tset_val | input | TIME_W | Time value |
| free_vld | input | 1 | Release strobe |
| free_idx | input | IDX_W | Slot being released |
| rd_idx | input | IDX_W | Slot to observe |
| rd_used | output | 1 | Used bit of observed slot |
| rd_done | output | 1 | Done bit of observed slot |
| rd_ctx | output | 1 | Context flag of observed slot |
| rd_ctype | output | CTYPE_W | Context type of observed slot |
| rd_reply | output | REPLY_W | Reply word of observed slot |
| rd_time | output | TIME_W | Time value of observed slot |
| proto_err | output | 1 | One-cycle pulse after an operation on an unused slot |

## Verification
Grant, index and full are combinational on the registered table, so they are due in the cycle the request is driven. The bench drives inputs at the falling edge and reads these outputs one time unit later. Every table update, including clears and the effect of a grant, appears on the read port after one rising edge, and `proto_err` rises in that same following cycle and falls a cycle later. The bench therefore samples registered results at the falling edge after the capturing edge. It checks the error pulse in two consecutive cycles to confirm its single-cycle width.

// File: rtl/tt_pkg.sv
package tt_pkg;
    localparam int TT_DEPTH   = 128;
    localparam int TT_REPLY_W = 32;
    localparam int TT_CTYPE_W = 8;
    localparam int TT_TIME_W  = 64;
endpackage

// File: rtl/tt_next_fit.sv
module tt_next_fit #(
    parameter int DEPTH = tt_pkg::TT_DEPTH,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] used_i,
    input  logic [IDX_W-1:0] start_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);
    logic [IDX_W:0] pos;
    logic [IDX_W:0] wrapped;

    // Scan slots starting at start_i; first free one wins.
    always_comb begin
        found_o = 1'b0;
        idx_o   = start_i;
        pos     = '0;
        wrapped = '0;
        for (int k = 0; k < DEPTH; k++) begin
            pos = {1'b0, start_i} + (IDX_W+1)'(k);
            wrapped = (pos >= (IDX_W+1)'(DEPTH)) ? pos - (IDX_W+1)'(DEPTH) : pos;
            if (!found_o && !used_i[wrapped[IDX_W-1:0]]) begin
                found_o = 1'b1;
                idx_o   = wrapped[IDX_W-1:0];
            end
        end
    end

    p_pick_is_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        found_o |-> !used_i[idx_o]);

    p_none_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !found_o |-> (&used_i));
endmodule

// File: rtl/tt_slot_array.sv
module tt_slot_array #(
    parameter int DEPTH   = tt_pkg::TT_DEPTH,
    parameter int REPLY_W = tt_pkg::TT_REPLY_W,
    parameter int CTYPE_W = tt_pkg::TT_CTYPE_W,
    parameter int TIME_W  = tt_pkg::TT_TIME_W,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               gnt_en_i,
    input  logic [IDX_W-1:0]   gnt_idx_i,
    input  logic               cmp_en_i,
    input  logic [IDX_W-1:0]   cmp_idx_i,
    input  logic [REPLY_W-1:0] cmp_reply_i,
    input  logic               cmp_ctx_i,
    input  logic [CTYPE_W-1:0] cmp_ctype_i,
    input  logic               tset_en_i,
    input  logic [IDX_W-1:0]   tset_idx_i,
    input  logic [TIME_W-1:0]  tset_val_i,
    input  logic               free_en_i,
    input  logic [IDX_W-1:0]   free_idx_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic               rd_used_o,
    output logic               rd_done_o,
    output logic               rd_ctx_o,
    output logic [CTYPE_W-1:0] rd_ctype_o,
    output logic [REPLY_W-1:0] rd_reply_o,
    output logic [TIME_W-1:0]  rd_time_o,
    output logic [DEPTH-1:0]   used_o
);
    typedef struct packed {
        logic               used;
        logic               done;
        logic               ctx;
        logic [CTYPE_W-1:0] ctype;
        logic [REPLY_W-1:0] reply;
        logic [TIME_W-1:0]  tstamp;
    } slot_t;

    slot_t tab_q [DEPTH];
    slot_t tab_d [DEPTH];

    always_comb begin
        tab_d = tab_q;
        if (clr_i) begin
            for (int i = 0; i < DEPTH; i++) tab_d[i] = '0;
        end else begin
            if (gnt_en_i) begin
                tab_d[gnt_idx_i]      = '0;
                tab_d[gnt_idx_i].used = 1'b1;
            end
            if (cmp_en_i) begin
                tab_d[cmp_idx_i].reply = cmp_reply_i;
                tab_d[cmp_idx_i].ctx   = cmp_ctx_i;
                tab_d[cmp_idx_i].ctype = cmp_ctype_i;
                tab_d[cmp_idx_i].done  = 1'b1;
            end
            if (tset_en_i) begin
                tab_d[tset_idx_i].tstamp = tset_val_i;
            end
            if (free_en_i) begin
                tab_d[free_idx_i].used = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tab_q <= '{default: '0};
        else        tab_q <= tab_d;
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_used
        assign used_o[g] = tab_q[g].used;
    end

    assign rd_used_o  = tab_q[rd_idx_i].used;
    assign rd_done_o  = tab_q[rd_idx_i].done;
    assign rd_ctx_o   = tab_q[rd_idx_i].ctx;
    assign rd_ctype_o = tab_q[rd_idx_i].ctype;
    assign rd_reply_o = tab_q[rd_idx_i].reply;
    assign rd_time_o  = tab_q[rd_idx_i].tstamp;

    // A fresh grant leaves a used, not-done, zero-reply slot.
    p_grant_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_en_i && !clr_i) |=> (tab_q[$past(gnt_idx_i)].used
                                  && !tab_q[$past(gnt_idx_i)].done
                                  && tab_q[$past(gnt_idx_i)].reply == '0));
endmodule

// File: rtl/tt_req_table.sv
module tt_req_table #(
    parameter int DEPTH   = tt_pkg::TT_DEPTH,
    parameter int REPLY_W = tt_pkg::TT_REPLY_W,
    parameter int CTYPE_W = tt_pkg::TT_CTYPE_W,
    parameter int TIME_W  = tt_pkg::TT_TIME_W,
    localparam int IDX_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               alloc_req,
    output logic               alloc_gnt,
    output logic [IDX_W-1:0]   alloc_idx,
    output logic               alloc_full,
    input  logic               cmp_vld,
    input  logic [IDX_W-1:0]   cmp_idx,
    input  logic [REPLY_W-1:0] cmp_reply,
    input  logic               cmp_ctx,
    input  logic [CTYPE_W-1:0] cmp_ctype,
    input  logic               tset_vld,
    input  logic [IDX_W-1:0]   tset_idx,
    input  logic [TIME_W-1:0]  tset_val,
    input  logic               free_vld,
    input  logic [IDX_W-1:0]   free_idx,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic               rd_used,
    output logic               rd_done,
    output logic               rd_ctx,
    output logic [CTYPE_W-1:0] rd_ctype,
    output logic [REPLY_W-1:0] rd_reply,
    output logic [TIME_W-1:0]  rd_time,
    output logic               proto_err
);
    typedef struct packed {
        logic [IDX_W-1:0] ptr;
        logic             err;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [DEPTH-1:0] used_vec;
    logic             fit_found;
    logic [IDX_W-1:0] fit_idx;
    logic             cmp_ok, tset_ok, free_ok, bad_op;

    tt_next_fit #(.DEPTH(DEPTH)) u_fit (
        .clk     (clk),
        .rst_n   (rst_n),
        .used_i  (used_vec),
        .start_i (ctl_q.ptr),
        .found_o (fit_found),
        .idx_o   (fit_idx)
    );

    assign alloc_full = !fit_found;
    assign alloc_idx  = fit_idx;
    assign alloc_gnt  = alloc_req && fit_found && !clr;

    // Operations are validated against the table as it stood before this edge.
    assign cmp_ok  = cmp_vld  && used_vec[cmp_idx]  && !clr;
    assign tset_ok = tset_vld && used_vec[tset_idx] && !clr;
    assign free_ok = free_vld && used_vec[free_idx] && !clr;
    assign bad_op  = !clr && ((cmp_vld  && !used_vec[cmp_idx])  ||
                              (tset_vld && !used_vec[tset_idx]) ||
                              (free_vld && !used_vec[free_idx]));

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = bad_op;
        if (clr) begin
            ctl_d.ptr = '0;
        end else if (alloc_gnt) begin
            ctl_d.ptr = (fit_idx == IDX_W'(DEPTH-1)) ? '0 : fit_idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign proto_err = ctl_q.err;

    tt_slot_array #(
        .DEPTH(DEPTH), .REPLY_W(REPLY_W), .CTYPE_W(CTYPE_W), .TIME_W(TIME_W)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .gnt_en_i    (alloc_gnt),
        .gnt_idx_i   (fit_idx),
        .cmp_en_i    (cmp_ok),
        .cmp_idx_i   (cmp_idx),
        .cmp_reply_i (cmp_reply),
        .cmp_ctx_i   (cmp_ctx),
        .cmp_ctype_i (cmp_ctype),
        .tset_en_i   (tset_ok),
        .tset_idx_i  (tset_idx),
        .tset_val_i  (tset_val),
        .free_en_i   (free_ok),
        .free_idx_i  (free_idx),
        .rd_idx_i    (rd_idx),
        .rd_used_o   (rd_used),
        .rd_done_o   (rd_done),
        .rd_ctx_o    (rd_ctx),
        .rd_ctype_o  (rd_ctype),
        .rd_reply_o  (rd_reply),
        .rd_time_o   (rd_time),
        .used_o      (used_vec)
    );

    p_ptr_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> ctl_q.ptr == (($past(alloc_idx) == IDX_W'(DEPTH-1))
                                    ? IDX_W'(0) : $past(alloc_idx) + IDX_W'(1)));

    p_bad_free_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && free_vld && !used_vec[free_idx]) |=> proto_err);

    p_full_holds_ptr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_full && !clr) |=> $stable(ctl_q.ptr));
endmodule

// File: tb/tb_tt_req_table.sv
`timescale 1ns/1ps
module tb_tt_req_table;
    localparam int DEPTH = 128;
    localparam int IDX_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic alloc_req = 1'b0;
    logic alloc_gnt, alloc_full;
    logic [IDX_W-1:0] alloc_idx;
    logic cmp_vld = 1'b0;
    logic [IDX_W-1:0] cmp_idx = '0;
    logic [31:0] cmp_reply = '0;
    logic cmp_ctx = 1'b0;
    logic [7:0] cmp_ctype = '0;
    logic tset_vld = 1'b0;
    logic [IDX_W-1:0] tset_idx = '0;
    logic [63:0] tset_val = '0;
    logic free_vld = 1'b0;
    logic [IDX_W-1:0] free_idx = '0;
    logic [IDX_W-1:0] rd_idx = '0;
    logic rd_used, rd_done, rd_ctx, proto_err;
    logic [7:0] rd_ctype;
    logic [31:0] rd_reply;
    logic [63:0] rd_time;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tt_req_table dut (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .alloc_req(alloc_req), .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx), .alloc_full(alloc_full),
        .cmp_vld(cmp_vld), .cmp_idx(cmp_idx), .cmp_reply(cmp_reply), .cmp_ctx(cmp_ctx), .cmp_ctype(cmp_ctype),
        .tset_vld(tset_vld), .tset_idx(tset_idx), .tset_val(tset_val),
        .free_vld(free_vld), .free_idx(free_idx),
        .rd_idx(rd_idx), .rd_used(rd_used), .rd_done(rd_done), .rd_ctx(rd_ctx),
        .rd_ctype(rd_ctype), .rd_reply(rd_reply), .rd_time(rd_time), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        alloc_req = 1'b0; cmp_vld = 1'b0; tset_vld = 1'b0; free_vld = 1'b0; clr = 1'b0;
    endtask

    task automatic look(input int idx);
        rd_idx = IDX_W'(idx);
        #1;
    endtask

    task automatic do_alloc(input int exp_idx, input string req);
        alloc_req = 1'b1;
        #1;
        chk({req, " grant"}, 64'(alloc_gnt), 64'd1);
        chk({req, " index"}, 64'(alloc_idx), 64'(exp_idx));
        step();
        quiet();
        look(exp_idx);
        chk({req, " used after grant"}, 64'(rd_used), 64'd1);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 3; i++) begin
            look(i * 50);
            chk("R1 reset used", 64'(rd_used), 64'd0);
            chk("R1 reset reply", 64'(rd_reply), 64'd0);
            chk("R1 reset time", rd_time, 64'd0);
        end
        chk("R1 reset err", 64'(proto_err), 64'd0);
        chk("R1 reset full", 64'(alloc_full), 64'd0);
    endtask

    task automatic t_first_allocs();
        do_alloc(0, "R1");
        do_alloc(1, "R2");
        do_alloc(2, "R2");
    endtask

    task automatic t_complete_and_stamp();
        cmp_vld = 1'b1; cmp_idx = 7'd1; cmp_reply = 32'hA5A5_0001; cmp_ctx = 1'b1; cmp_ctype = 8'h3C;
        tset_vld = 1'b1; tset_idx = 7'd1; tset_val = 64'h1122_3344_5566_7788;
        step();
        quiet();
        look(1);
        chk("R6 done", 64'(rd_done), 64'd1);
        chk("R6 reply", 64'(rd_reply), 64'hA5A5_0001);
        chk("R6 ctx", 64'(rd_ctx), 64'd1);
        chk("R6 ctype", 64'(rd_ctype), 64'h3C);
        chk("R11 time", rd_time, 64'h1122_3344_5566_7788);
        chk("R6 no err", 64'(proto_err), 64'd0);
    endtask

    task automatic t_free_out_of_order();
        free_vld = 1'b1; free_idx = 7'd1;
        step();
        quiet();
        look(1);
        chk("R7 used cleared", 64'(rd_used), 64'd0);
        chk("R7 done kept", 64'(rd_done), 64'd1);
        chk("R7 reply kept", 64'(rd_reply), 64'hA5A5_0001);
        chk("R7 time kept", rd_time, 64'h1122_3344_5566_7788);
        do_alloc(3, "R8");
    endtask

    task automatic t_fill_and_wrap();
        for (int i = 4; i < DEPTH; i++) do_alloc(i, "R8");
        do_alloc(1, "R3");
        look(1);
        chk("R4 reply cleared", 64'(rd_reply), 64'd0);
        chk("R4 done cleared", 64'(rd_done), 64'd0);
        chk("R4 ctx cleared", 64'(rd_ctx), 64'd0);
        chk("R4 ctype cleared", 64'(rd_ctype), 64'd0);
        chk("R4 time cleared", rd_time, 64'd0);
        alloc_req = 1'b1;
        #1;
        chk("R5 full", 64'(alloc_full), 64'd1);
        chk("R5 no grant", 64'(alloc_gnt), 64'd0);
        step();
        quiet();
        #1;
        chk("R5 still full", 64'(alloc_full), 64'd1);
    endtask

    task automatic t_free_with_alloc();
        free_vld = 1'b1; free_idx = 7'd5; alloc_req = 1'b1;
        #1;
        chk("R9 no grant on same-cycle free", 64'(alloc_gnt), 64'd0);
        step();
        quiet();
        #1;
        chk("R9 free visible next cycle", 64'(alloc_full), 64'd0);
        do_alloc(5, "R9");
    endtask

    task automatic t_protocol_error();
        free_vld = 1'b1; free_idx = 7'd7;
        step();
        quiet();
        #1;
        chk("R10 valid free no err", 64'(proto_err), 64'd0);
        cmp_vld = 1'b1; cmp_idx = 7'd7; cmp_reply = 32'hDEAD_BEEF; cmp_ctx = 1'b1; cmp_ctype = 8'hFF;
        tset_vld = 1'b1; tset_idx = 7'd7; tset_val = 64'hFFFF_0000_FFFF_0000;
        step();
        quiet();
        look(7);
        chk("R10 err pulse", 64'(proto_err), 64'd1);
        chk("R10 reply untouched", 64'(rd_reply), 64'd0);
        chk("R10 done untouched", 64'(rd_done), 64'd0);
        chk("R10 time untouched", rd_time, 64'd0);
        chk("R10 used untouched", 64'(rd_used), 64'd0);
        step();
        chk("R10 err one cycle", 64'(proto_err), 64'd0);
        free_vld = 1'b1; free_idx = 7'd7;
        step();
        quiet();
        #1;
        chk("R10 double free err", 64'(proto_err), 64'd1);
    endtask

    task automatic t_clear();
        cmp_vld = 1'b1; cmp_idx = 7'd0; cmp_reply = 32'h1234_5678;
        alloc_req = 1'b1; clr = 1'b1;
        #1;
        chk("R12 no grant during clear", 64'(alloc_gnt), 64'd0);
        step();
        quiet();
        look(0);
        chk("R12 slot0 used", 64'(rd_used), 64'd0);
        chk("R12 slot0 reply", 64'(rd_reply), 64'd0);
        look(1);
        chk("R1 clear done", 64'(rd_done), 64'd0);
        chk("R1 clear err", 64'(proto_err), 64'd0);
        do_alloc(0, "R1");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_first_allocs();
        t_complete_and_stamp();
        t_free_out_of_order();
        t_fill_and_wrap();
        t_free_with_alloc();
        t_protocol_error();
        t_clear();
        finish_run();
    end
endmodule